// File: doc/BRIEF.md
# Chip-Select-Gated Slave FIFO Access Port

This block lets an external bus master move data into and out of four internal endpoint FIFOs. The master drives a 2-bit endpoint address, a data bus, and four active-high controls: read, write, output enable and packet end. All four controls are ignored unless the active-low chip select is low. The block does not hold any storage. It sends push, pop and commit pulses, with the selected endpoint index and the write data, to the FIFO storage beside it. It reads back each endpoint's fill level and head-of-queue word.

A mode input picks how the controls are interpreted. In clocked mode, read, write and packet end are qualifiers sampled on every rising edge of the interface clock, and each sampled edge is one transfer. In strobe mode the controls are free-running pulses. Each one is brought through a two-stage synchroniser, and one transfer is counted when the synchronised pulse falls, however long it was held. Each endpoint is set on its own to byte or word width. That width sets which lanes of the write data are kept and which lanes of the read bus are driven.

Full, empty and level-threshold flags always show the endpoint currently on the address lines. A write while output enable is active is a bus conflict. The write is dropped and a sticky error flag is raised.

Top module: `slvp_port`

## Requirements
- R1: The endpoint index reported with each push, pop or commit (`fifo_sel`) equals the value of `ext_addr` at the moment the transfer was accepted.
- R2: While `ext_cs_n` is high, read, write, packet end and output enable have no effect: no push, pop or commit pulse is produced and `ext_dout_en` is 2'b00.
- R3: In clocked mode (`async_mode`=0), every rising clock edge that samples write high (chip select low, output enable low, addressed FIFO not full) produces exactly one `fifo_push` pulse in the following cycle, carrying the sampled `ext_din`.
- R4: In clocked mode, every rising edge that samples read high (chip select low, addressed FIFO not empty) produces exactly one `fifo_pop` pulse in the following cycle.
- R5: In strobe mode (`async_mode`=1), a write, read or packet-end pulse produces exactly one push, pop or commit. The pulse appears only after its falling edge has passed a two-flop synchroniser, and nothing is produced while the pulse is still held.
- R6: The endpoint width is set by `ep_wide` (bit n=1 is word width for endpoint n, 0 is byte width). For a byte endpoint, `fifo_wdata[15:8]` and `ext_dout[15:8]` are zero and `ext_dout_en` is 2'b01. For a word endpoint, all 16 bits pass and `ext_dout_en` is 2'b11, in both cases only while chip select and output enable are asserted.
- R7: A write to an endpoint whose level equals DEPTH is ignored, with no push. A read from an endpoint whose level is 0 is ignored, with no pop.
- R8: `flag_empty` is 1 when the addressed level is 0. `flag_full` is 1 when it equals DEPTH. `flag_prog` is 1 when it is at least PROG_THR. All three follow `ext_addr` with no clock delay.
- R9: A write accepted while output enable is also active produces no push and sets `proto_err`, which stays 1 until reset.
- R10: Packet end with chip select low produces one `fifo_commit` pulse for the addressed endpoint (one per sampled edge in clocked mode, one per falling strobe edge in strobe mode).
- R11: After reset, `fifo_push`, `fifo_pop`, `fifo_commit` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface / internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | 0 = clocked qualifiers, 1 = free strobes |
| ep_wide | input | 4 | Per-endpoint width, 1 = word |
| ext_cs_n | input | 1 | Active-low chip select |
| ext_rd | input | 1 | Read control |
| ext_wr | input | 1 | Write control |
| ext_oe | input | 1 | Output enable control |
| ext_pktend | input | 1 | Commit partial packet |
| ext_addr | input | 2 | Endpoint select |
| ext_din | input | 16 | Write data from master |
| ext_dout | output | 16 | Read data to master |
| ext_dout_en | output | 2 | Per-byte-lane drive enable |
| flag_full | output | 1 | Addressed FIFO full |
| flag_empty | output | 1 | Addressed FIFO empty |
| flag_prog | output | 1 | Addressed FIFO at or above threshold |
| proto_err | output | 1 | Sticky write/output-enable conflict |
| fifo_level | input | 36 | Four packed 9-bit fill levels, endpoint 0 in the low bits |
| fifo_rdata | input | 16 | Head word of the addressed FIFO |
| fifo_push | output | 1 | Write one entry |
| fifo_pop | output | 1 | Remove one entry |
| fifo_commit | output | 1 | Commit partial packet |
| fifo_sel | output | 2 | Endpoint of the current pulse |
| fifo_wdata | output | 16 | Data for the push |

## Verification
In strobe mode, the bench holds a write pulse for several cycles and confirms that no push appears before release and exactly one appears after it. A design that counted on the rising edge, or on the level, would push early or many times. It writes to a full endpoint and reads from an empty one. A missing guard there would emit pulses that overflow or underflow the storage. It toggles every control with chip select high, and the same controls with output enable held during a write, so that leaking strobes or a conflicting write that still pushes would show up as extra pulses or a clear error flag. Byte-width endpoints are checked for zeroed upper lanes, which a design that ignored the width setting would leave populated.

// File: rtl/slvp_pkg.sv
package slvp_pkg;
  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;

  // strobe indices on the synchroniser vector
  localparam int S_RD  = 0;
  localparam int S_WR  = 1;
  localparam int S_PE  = 2;
  localparam int S_OE  = 3;
  localparam int S_NUM = 4;

  typedef struct packed {
    logic push;
    logic pop;
    logic commit;
    logic conflict;
    logic any;
  } xfer_t;

  // lanes that carry data at a given endpoint width
  function automatic logic [LANES-1:0] lane_enable(input logic wide);
    return wide ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
  endfunction

  // clear unused upper lanes for byte endpoints
  function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_W-1:0] d,
                                                 input logic wide);
    return wide ? d : {{(BUS_W-LANE_W){1'b0}}, d[LANE_W-1:0]};
  endfunction
endpackage

// File: rtl/slvp_strobe_sync.sv
module slvp_strobe_sync #(
  parameter int N         = 4,
  parameter int STAGES    = 2,
  parameter logic [N-1:0] EDGE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] evt_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], raw_i[i]};
    end

    if (EDGE_MASK[i]) begin : g_fall
      // deasserting edge of the synchronised strobe
      assign evt_o[i] = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

      // R5: a falling event can never repeat on the next cycle
      p_single_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[i] |=> !evt_o[i]);
    end else begin : g_level
      assign evt_o[i] = chain_q[CHAIN-2];
    end
  end
endmodule

// File: rtl/slvp_flag_gen.sv
module slvp_flag_gen #(
  parameter int ADDR_W   = 2,
  parameter int DEPTH    = 256,
  parameter int PROG_THR = 192,
  localparam int NUM_EP  = 1 << ADDR_W,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic [NUM_EP*LVL_W-1:0] level_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    full_o,
  output logic                    empty_o,
  output logic                    prog_o
);
  function automatic logic lvl_full(input logic [LVL_W-1:0] l);
    return l == LVL_W'(DEPTH);
  endfunction

  function automatic logic lvl_empty(input logic [LVL_W-1:0] l);
    return l == '0;
  endfunction

  function automatic logic lvl_prog(input logic [LVL_W-1:0] l);
    return l >= LVL_W'(PROG_THR);
  endfunction

  logic [LVL_W-1:0] lvl_sel;
  assign lvl_sel = level_i[addr_i*LVL_W +: LVL_W];

  assign full_o  = lvl_full(lvl_sel);
  assign empty_o = lvl_empty(lvl_sel);
  assign prog_o  = lvl_prog(lvl_sel);
endmodule

// File: rtl/slvp_xfer_ctrl.sv
module slvp_xfer_ctrl
  import slvp_pkg::*;
(
  input  logic             async_mode,
  input  logic             cs_n,
  input  logic             rd,
  input  logic             wr,
  input  logic             oe,
  input  logic             pktend,
  input  logic [S_NUM-1:0] sync_evt,
  input  logic             full,
  input  logic             empty,
  output xfer_t            xfer_o
);
  logic cs;
  logic rd_evt, wr_evt, pe_evt, oe_act;

  assign cs = ~cs_n;

  always_comb begin
    if (async_mode) begin
      rd_evt = sync_evt[S_RD];
      wr_evt = sync_evt[S_WR];
      pe_evt = sync_evt[S_PE];
      oe_act = sync_evt[S_OE];
    end else begin
      rd_evt = cs & rd;
      wr_evt = cs & wr;
      pe_evt = cs & pktend;
      oe_act = cs & oe;
    end
  end

  always_comb begin
    xfer_o.conflict = wr_evt & oe_act;
    xfer_o.push     = wr_evt & ~oe_act & ~full;
    xfer_o.pop      = rd_evt & ~empty;
    xfer_o.commit   = pe_evt;
    xfer_o.any      = xfer_o.push | xfer_o.pop | xfer_o.commit;
  end
endmodule

// File: rtl/slvp_port.sv
module slvp_port
  import slvp_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DEPTH    = 256,
  parameter int PROG_THR = 192,
  parameter int SYNC_STG = 2,
  localparam int NUM_EP  = 1 << ADDR_W,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    async_mode,
  input  logic [NUM_EP-1:0]       ep_wide,
  input  logic                    ext_cs_n,
  input  logic                    ext_rd,
  input  logic                    ext_wr,
  input  logic                    ext_oe,
  input  logic                    ext_pktend,
  input  logic [ADDR_W-1:0]       ext_addr,
  input  logic [BUS_W-1:0]        ext_din,
  output logic [BUS_W-1:0]        ext_dout,
  output logic [LANES-1:0]        ext_dout_en,
  output logic                    flag_full,
  output logic                    flag_empty,
  output logic                    flag_prog,
  output logic                    proto_err,
  input  logic [NUM_EP*LVL_W-1:0] fifo_level,
  input  logic [BUS_W-1:0]        fifo_rdata,
  output logic                    fifo_push,
  output logic                    fifo_pop,
  output logic                    fifo_commit,
  output logic [ADDR_W-1:0]       fifo_sel,
  output logic [BUS_W-1:0]        fifo_wdata
);
  localparam logic [S_NUM-1:0] EDGE_BITS = S_NUM'((1 << S_RD) | (1 << S_WR) | (1 << S_PE));

  logic             cs;
  logic             sel_wide;
  logic [S_NUM-1:0] gated_raw;
  logic [S_NUM-1:0] sync_evt;
  xfer_t            xfer;

  assign cs       = ~ext_cs_n;
  assign sel_wide = ep_wide[ext_addr];

  // chip-select gating ahead of the synchronisers
  always_comb begin
    gated_raw        = '0;
    gated_raw[S_RD]  = cs & ext_rd;
    gated_raw[S_WR]  = cs & ext_wr;
    gated_raw[S_PE]  = cs & ext_pktend;
    gated_raw[S_OE]  = cs & ext_oe;
  end

  slvp_strobe_sync #(
    .N(S_NUM), .STAGES(SYNC_STG), .EDGE_MASK(EDGE_BITS)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(gated_raw), .evt_o(sync_evt)
  );

  slvp_flag_gen #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_THR(PROG_THR)
  ) u_flags (
    .level_i(fifo_level), .addr_i(ext_addr),
    .full_o(flag_full), .empty_o(flag_empty), .prog_o(flag_prog)
  );

  slvp_xfer_ctrl u_ctrl (
    .async_mode(async_mode), .cs_n(ext_cs_n),
    .rd(ext_rd), .wr(ext_wr), .oe(ext_oe), .pktend(ext_pktend),
    .sync_evt(sync_evt), .full(flag_full), .empty(flag_empty),
    .xfer_o(xfer)
  );

  // registered storage-side pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_push   <= 1'b0;
      fifo_pop    <= 1'b0;
      fifo_commit <= 1'b0;
      fifo_sel    <= '0;
      fifo_wdata  <= '0;
      proto_err   <= 1'b0;
    end else begin
      fifo_push   <= xfer.push;
      fifo_pop    <= xfer.pop;
      fifo_commit <= xfer.commit;
      if (xfer.any) fifo_sel <= ext_addr;
      if (xfer.push) fifo_wdata <= lane_mask(ext_din, sel_wide);
      if (xfer.conflict) proto_err <= 1'b1;
    end
  end

  // read bus towards the master
  assign ext_dout    = lane_mask(fifo_rdata, sel_wide);
  assign ext_dout_en = (cs & ext_oe) ? lane_enable(sel_wide) : '0;

  // R7: no push into a full endpoint
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(!flag_full));

  // R7: no pop from an empty endpoint
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(!flag_empty));

  // R9: conflicting write never pushes
  p_conflict_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer.conflict |=> !fifo_push);

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R2: clocked mode with chip select high yields no pulses
  p_cs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && ext_cs_n) |=> !(fifo_push || fifo_pop || fifo_commit));

  // R1: endpoint index follows address of an accepted transfer
  p_sel_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer.any |=> fifo_sel == $past(ext_addr));

  // R6: output lanes never enabled without chip select
  p_lane_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs_n |-> ext_dout_en == '0);
endmodule

// File: tb/tb_slvp_port.sv
module tb_slvp_port;
  localparam int DEPTH    = 256;
  localparam int PROG_THR = 192;
  localparam int LVL_W    = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        async_mode = 1'b0;
  logic [3:0]  ep_wide = 4'b1000;
  logic        ext_cs_n = 1'b1, ext_rd = 1'b0, ext_wr = 1'b0, ext_oe = 1'b0, ext_pktend = 1'b0;
  logic [1:0]  ext_addr = 2'd0;
  logic [15:0] ext_din = 16'h0;
  logic [15:0] ext_dout;
  logic [1:0]  ext_dout_en;
  logic        flag_full, flag_empty, flag_prog, proto_err;
  logic [35:0] fifo_level;
  logic [15:0] fifo_rdata = 16'hBEEF;
  logic        fifo_push, fifo_pop, fifo_commit;
  logic [1:0]  fifo_sel;
  logic [15:0] fifo_wdata;

  // endpoint levels: 0 empty, 1 full, 2 at threshold, 3 just below
  assign fifo_level = {LVL_W'(PROG_THR - 1), LVL_W'(PROG_THR), LVL_W'(DEPTH), LVL_W'(0)};

  slvp_port dut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .ep_wide(ep_wide),
    .ext_cs_n(ext_cs_n), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_oe(ext_oe),
    .ext_pktend(ext_pktend), .ext_addr(ext_addr), .ext_din(ext_din),
    .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
    .flag_full(flag_full), .flag_empty(flag_empty), .flag_prog(flag_prog),
    .proto_err(proto_err), .fifo_level(fifo_level), .fifo_rdata(fifo_rdata),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_commit(fifo_commit),
    .fifo_sel(fifo_sel), .fifo_wdata(fifo_wdata)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_push = 0, n_pop = 0, n_commit = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (fifo_push)   n_push   <= n_push + 1;
    if (fifo_pop)    n_pop    <= n_pop + 1;
    if (fifo_commit) n_commit <= n_commit + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11", "push after reset", fifo_push, 0);
    check("R11", "pop after reset", fifo_pop, 0);
    check("R11", "commit after reset", fifo_commit, 0);
    check("R11", "err after reset", proto_err, 0);
  endtask

  task automatic t_flags();
    for (int a = 0; a < 4; a++) begin
      ext_addr = 2'(a);
      #1;
      check("R8", $sformatf("empty ep%0d", a), flag_empty, a == 0);
      check("R8", $sformatf("full ep%0d", a), flag_full, a == 1);
      check("R8", $sformatf("prog ep%0d", a), flag_prog, (a == 1) || (a == 2));
    end
  endtask

  task automatic t_sync_write();
    int base;
    @(negedge clk);
    base = n_push;
    ext_addr = 2'd3; ext_cs_n = 0; ext_wr = 1; ext_din = 16'h1234;
    @(negedge clk);
    check("R3", "push one cycle after sample", fifo_push, 1);
    check("R3", "wdata word", fifo_wdata, 16'h1234);
    check("R1", "sel ep3", fifo_sel, 3);
    ext_din = 16'h5678;
    idle(2);
    ext_wr = 0; ext_cs_n = 1;
    idle(3);
    check("R3", "push count for 3 sampled edges", n_push - base, 3);
    check("R3", "last wdata", fifo_wdata, 16'h5678);
  endtask

  task automatic t_width();
    int base = n_push;
    ext_addr = 2'd2; ext_cs_n = 0; ext_wr = 1; ext_din = 16'hABCD;
    @(negedge clk);
    ext_wr = 0;
    idle(2);
    check("R6", "byte push count", n_push - base, 1);
    check("R6", "byte wdata upper lane zero", fifo_wdata, 16'h00CD);
    check("R1", "sel ep2", fifo_sel, 2);
    ext_oe = 1; #1;
    check("R6", "byte lane enable", ext_dout_en, 2'b01);
    check("R6", "byte dout", ext_dout, 16'h00EF);
    ext_addr = 2'd3; #1;
    check("R6", "word lane enable", ext_dout_en, 2'b11);
    check("R6", "word dout", ext_dout, 16'hBEEF);
    ext_oe = 0; ext_cs_n = 1; #1;
    check("R6", "no lanes when deselected", ext_dout_en, 2'b00);
    idle(1);
  endtask

  task automatic t_sync_read();
    int base = n_pop;
    ext_addr = 2'd3; ext_cs_n = 0; ext_rd = 1;
    idle(2);
    ext_rd = 0; ext_cs_n = 1;
    idle(3);
    check("R4", "pop count for 2 sampled edges", n_pop - base, 2);
  endtask

  task automatic t_guard();
    int bp = n_push, bo = n_pop;
    ext_cs_n = 0; ext_addr = 2'd1; ext_wr = 1;
    idle(3);
    ext_wr = 0; ext_addr = 2'd0; ext_rd = 1;
    idle(3);
    ext_rd = 0; ext_cs_n = 1;
    idle(3);
    check("R7", "no push into full", n_push - bp, 0);
    check("R7", "no pop from empty", n_pop - bo, 0);
  endtask

  task automatic t_deselect();
    int bp = n_push, bo = n_pop, bc = n_commit;
    ext_cs_n = 1; ext_addr = 2'd3;
    ext_wr = 1; ext_rd = 1; ext_pktend = 1; ext_oe = 1;
    #1;
    check("R2", "no drive while deselected", ext_dout_en, 0);
    idle(3);
    ext_wr = 0; ext_rd = 0; ext_pktend = 0; ext_oe = 0;
    idle(5);
    check("R2", "no push while deselected", n_push - bp, 0);
    check("R2", "no pop while deselected", n_pop - bo, 0);
    check("R2", "no commit while deselected", n_commit - bc, 0);
  endtask

  task automatic t_pktend();
    int bc = n_commit;
    ext_cs_n = 0; ext_addr = 2'd2; ext_pktend = 1;
    @(negedge clk);
    ext_pktend = 0; ext_cs_n = 1;
    check("R10", "commit pulse", fifo_commit, 1);
    check("R1", "commit sel ep2", fifo_sel, 2);
    idle(2);
    check("R10", "commit count", n_commit - bc, 1);
  endtask

  task automatic t_conflict();
    int bp = n_push;
    check("R9", "err clear before conflict", proto_err, 0);
    ext_cs_n = 0; ext_addr = 2'd3; ext_oe = 1; ext_wr = 1;
    @(negedge clk);
    ext_wr = 0; ext_oe = 0; ext_cs_n = 1;
    idle(4);
    check("R9", "conflicting write dropped", n_push - bp, 0);
    check("R9", "err set", proto_err, 1);
  endtask

  task automatic t_async();
    int bp, bo, bc;
    async_mode = 1;
    idle(4);
    bp = n_push;
    ext_cs_n = 0; ext_addr = 2'd3; ext_din = 16'h9A9A; ext_wr = 1;
    idle(6);
    check("R5", "no push while strobe held", n_push - bp, 0);
    ext_wr = 0;
    idle(6);
    check("R5", "one push per strobe", n_push - bp, 1);
    check("R5", "async wdata", fifo_wdata, 16'h9A9A);
    bo = n_pop;
    ext_rd = 1; idle(2); ext_rd = 0;
    idle(6);
    check("R5", "one pop per strobe", n_pop - bo, 1);
    bc = n_commit;
    ext_addr = 2'd2;
    ext_pktend = 1; idle(3); ext_pktend = 0;
    idle(6);
    check("R10", "async commit once", n_commit - bc, 1);
    check("R1", "async commit sel", fifo_sel, 2);
    ext_cs_n = 1;
    bp = n_push;
    ext_wr = 1; idle(3); ext_wr = 0;
    idle(6);
    check("R2", "async deselected strobe ignored", n_push - bp, 0);
    check("R9", "err still set", proto_err, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_flags();
    t_sync_write();
    t_width();
    t_sync_read();
    t_guard();
    t_deselect();
    t_pktend();
    t_conflict();
    t_async();
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule